// File: doc/BRIEF.md
# Restoring Binary Divider

This block divides an unsigned double-width dividend by a single-width divisor over several clock cycles. It uses the classic restoring method. The upper half of the dividend goes into a partial-remainder register and the lower half into a quotient register. The divisor is held in a third register. On every quotient bit, the carry bit, the partial remainder and the quotient register shift left together. The block then makes a trial subtraction of the divisor as a complement-and-add. The end carry of that addition tells whether the partial remainder was at least the divisor. If it was, a 1 enters the low quotient bit. If it was not, the bit stays 0 and the next cycle adds the divisor back to undo the subtraction.

Before it iterates, the block compares the upper dividend half with the divisor, using the same adder. When the quotient would not fit in the result width, it raises a divide-overflow flag and finishes at once. This case includes a zero divisor. Results are read from `quotient` and `remainder` when `done` pulses, and they stay there until the next accepted start.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted and after it is released, `quotient`, `remainder`, `div_ovf` and `done` are all 0.
- R2: If the upper WIDTH bits of the dividend are greater than or equal to the divisor (a zero divisor always meets this), the operation ends with `div_ovf`=1. In that case `quotient` holds the lower dividend half and `remainder` holds the upper dividend half.
- R3: Otherwise, when `done` pulses, `div_ovf`=0, `quotient` equals floor(dividend / divisor), and quotient × divisor + remainder equals the dividend.
- R4: When an operation completes without overflow, `remainder` is strictly less than the divisor.
- R5: Let the rising edge that samples `start` be edge 0. `done` is high after edge 1 when the operation overflows. Otherwise `done` is high after edge 1 + 2·WIDTH + z, where z is the number of 0 bits in the quotient: each restore costs one extra cycle.
- R6: `done` is high for exactly one cycle per operation. `quotient` and `remainder` do not change until the next accepted start.
- R7: A `start` that arrives while an operation is in progress has no effect. The running operation delivers the results of its own operands, at its own R5 time.
- R8: Divisors whose most significant bit is 1 give correct results. In that case the bit shifted out of the partial remainder takes part in the comparison.
- R9: `div_ovf` drops to 0 on the cycle after a start is accepted. It keeps the value of the last operation until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only when idle |
| dividend | input | 2*WIDTH | Unsigned dividend, sampled with an accepted start |
| divisor | input | WIDTH | Unsigned divisor, sampled with an accepted start |
| quotient | output | WIDTH | Quotient of the last operation |
| remainder | output | WIDTH | Remainder of the last operation |
| div_ovf | output | 1 | Last operation overflowed or divided by zero |
| done | output | 1 | One-cycle pulse when an operation ends |

## Verification
The bench builds the block with WIDTH=6 and the explicit ripple-carry adder variant. At that width a short run can reach every divisor value, including every divisor with its top bit set, where the shifted-out carry decides the quotient bit. The small width also makes all-ones and all-zero quotients easy to hit, so the latency depends visibly on the number of restore cycles. Overflow is driven at its exact boundary (upper half equal to the divisor), above it, and with a zero divisor.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

   // Sequencer states of the divider
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CHECK   = 3'd1,
      ST_SHIFT   = 3'd2,
      ST_TRIAL   = 3'd3,
      ST_RESTORE = 3'd4
   } rdiv_state_t;

   // One-hot step strobes from the sequencer to the datapath
   typedef struct packed {
      logic load;
      logic check;
      logic shift;
      logic trial;
      logic restore;
   } rdiv_step_t;

   localparam int ADDER_BEHAVIOURAL = 0;
   localparam int ADDER_RIPPLE      = 1;

endpackage

// File: rtl/rdiv_addsub.sv
module rdiv_addsub #(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = 1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   // Complementer: XOR each divisor bit with the subtract control
   logic [WIDTH-1:0] b_eff;
   assign b_eff = b ^ {WIDTH{sub}};

   generate
      if (ADDER_STYLE == rdiv_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_fa
            assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
         end
         assign cout = carry[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] full;
         assign full = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
         assign sum  = full[WIDTH-1:0];
         assign cout = full[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath
   import rdiv_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = 1,
   localparam int DW         = 2 * WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rdiv_step_t       step,
   input  logic [DW-1:0]    dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             cout,
   output logic             ge
);
   logic             e_q;
   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] q_q;
   logic [WIDTH-1:0] b_q;
   logic [WIDTH-1:0] sum;

   // Shared adder: subtracts for the check and the trial, adds for the restore
   rdiv_addsub #(
      .WIDTH       (WIDTH),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_addsub (
      .a    (a_q),
      .b    (b_q),
      .sub  (~step.restore),
      .sum  (sum),
      .cout (cout)
   );

   // A bit shifted out of A already makes E:A exceed any divisor
   assign ge = e_q | cout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_q <= 1'b0;
         a_q <= '0;
         q_q <= '0;
         b_q <= '0;
      end else if (step.load) begin
         e_q <= 1'b0;
         a_q <= dividend[DW-1:WIDTH];
         q_q <= dividend[WIDTH-1:0];
         b_q <= divisor;
      end else if (step.shift) begin
         {e_q, a_q, q_q} <= {a_q, q_q, 1'b0};
      end else if (step.trial) begin
         a_q <= sum;
         if (ge) begin
            q_q[0] <= 1'b1;
         end
      end else if (step.restore) begin
         a_q <= sum;
      end
   end

   assign quotient  = q_q;
   assign remainder = a_q;

endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
   import rdiv_pkg::*;
#(
   parameter int WIDTH  = 8,
   localparam int CW    = $clog2(WIDTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       cout,
   input  logic       ge,
   output rdiv_step_t step,
   output logic       idle,
   output logic       done,
   output logic       div_ovf
);
   rdiv_state_t    state;
   logic [CW-1:0]  bits_left;
   logic           last_bit;

   assign idle     = (state == ST_IDLE);
   assign last_bit = (bits_left == CW'(1));

   always_comb begin
      step         = '0;
      step.load    = idle & start;
      step.check   = (state == ST_CHECK);
      step.shift   = (state == ST_SHIFT);
      step.trial   = (state == ST_TRIAL);
      step.restore = (state == ST_RESTORE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bits_left <= '0;
         done      <= 1'b0;
         div_ovf   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  div_ovf <= 1'b0;
                  state   <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (cout) begin
                  div_ovf <= 1'b1;
                  done    <= 1'b1;
                  state   <= ST_IDLE;
               end else begin
                  bits_left <= CW'(WIDTH);
                  state     <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               state <= ST_TRIAL;
            end
            ST_TRIAL: begin
               if (ge) begin
                  bits_left <= bits_left - CW'(1);
                  if (last_bit) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_SHIFT;
                  end
               end else begin
                  state <= ST_RESTORE;
               end
            end
            ST_RESTORE: begin
               bits_left <= bits_left - CW'(1);
               if (last_bit) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_SHIFT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
   import rdiv_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = ADDER_RIPPLE,
   localparam int DW         = 2 * WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DW-1:0]    dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             div_ovf,
   output logic             done
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("restoring_divider: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != ADDER_BEHAVIOURAL && ADDER_STYLE != ADDER_RIPPLE) begin : g_bad_style
         $error("restoring_divider: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   rdiv_step_t step;
   logic       cout;
   logic       ge;
   logic       idle;

   rdiv_ctrl #(
      .WIDTH (WIDTH)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cout    (cout),
      .ge      (ge),
      .step    (step),
      .idle    (idle),
      .done    (done),
      .div_ovf (div_ovf)
   );

   rdiv_datapath #(
      .WIDTH       (WIDTH),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .dividend  (dividend),
      .divisor   (divisor),
      .quotient  (quotient),
      .remainder (remainder),
      .cout      (cout),
      .ge        (ge)
   );

endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
   parameter int WIDTH  = 8,
   localparam int DW    = 2 * WIDTH
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [DW-1:0]    dividend,
   input logic [WIDTH-1:0] divisor,
   input logic [WIDTH-1:0] quotient,
   input logic [WIDTH-1:0] remainder,
   input logic             div_ovf,
   input logic             done,
   input logic             idle
);
   logic [DW-1:0]    lat_dd;
   logic [WIDTH-1:0] lat_dv;
   logic [DW-1:0]    recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_dd <= '0;
         lat_dv <= '0;
      end else if (idle && start) begin
         lat_dd <= dividend;
         lat_dv <= divisor;
      end
   end

   assign recon = DW'(quotient) * DW'(lat_dv) + DW'(remainder);

   // R2
   ovf_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (div_ovf == (lat_dd[DW-1:WIDTH] >= lat_dv)));

   // R3
   identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_ovf) |-> (recon == lat_dd));

   // R4
   rem_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_ovf) |-> (remainder < lat_dv));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !start) |=> ($stable(quotient) && $stable(remainder)));

   // R9
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start) |=> !div_ovf);

endmodule

bind restoring_divider rdiv_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/restoring_divider_tb.sv
`timescale 1ns/1ps
module restoring_divider_tb;
   localparam int W  = 6;
   localparam int DW = 2 * W;

   typedef struct {
      logic [W-1:0]  q;
      logic [W-1:0]  r;
      logic          ovf;
      logic [DW-1:0] dd;
      logic [W-1:0]  dv;
      longint        due;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] dividend = '0;
   logic [W-1:0]  divisor = '0;
   logic [W-1:0]  quotient;
   logic [W-1:0]  remainder;
   logic          div_ovf;
   logic          done;

   longint cyc = 0;
   int     n_checks = 0;
   int     n_fails = 0;
   exp_t   sbq[$];
   bit     hold_pending = 0;
   logic [W-1:0] hq, hr;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   restoring_divider #(.WIDTH(W), .ADDER_STYLE(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
      .divisor(divisor), .quotient(quotient), .remainder(remainder),
      .div_ovf(div_ovf), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Driver: computes the expected item and pushes it to the scoreboard
   task automatic issue(input logic [DW-1:0] dd, input logic [W-1:0] dv,
                        input bit poke, input string tag);
      exp_t e;
      logic [W-1:0] hi;
      hi = dd[DW-1:W];
      e.dd = dd; e.dv = dv; e.tag = tag;
      @(negedge clk);
      if (hi >= dv) begin
         e.ovf = 1'b1; e.q = dd[W-1:0]; e.r = hi;
         e.due = cyc + 2;
      end else begin
         e.ovf = 1'b0;
         e.q = W'(dd / DW'(dv));
         e.r = W'(dd % DW'(dv));
         e.due = cyc + 2 + 2 * W + (W - $countones(e.q));
      end
      dividend = dd; divisor = dv; start = 1'b1;
      sbq.push_back(e);
      @(negedge clk);
      start = 1'b0;
      if (poke && !e.ovf) begin
         // R7: a start while busy must be ignored
         repeat (2) @(negedge clk);
         dividend = ~dd; divisor = dv ^ W'(1); start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (sbq.size() == 0);
      @(negedge clk);
   endtask

   // Monitor: pops and compares as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pending) begin
            hold_pending = 0;
            check(done == 1'b0, "R6", "done pulse width", done, 0);
            check(quotient == hq && remainder == hr, "R6", "result hold",
                  {quotient, remainder}, {hq, hr});
         end
         if (done) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R6", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               check(cyc == e.due, "R5", {e.tag, " latency"}, cyc, e.due);
               check(div_ovf == e.ovf, e.ovf ? "R2" : "R3",
                     {e.tag, " overflow flag"}, div_ovf, e.ovf);
               check(quotient == e.q, e.ovf ? "R2" : "R3",
                     {e.tag, " quotient"}, quotient, e.q);
               check(remainder == e.r, e.ovf ? "R2" : "R3",
                     {e.tag, " remainder"}, remainder, e.r);
               if (!e.ovf) begin
                  check(remainder < e.dv, "R4", {e.tag, " remainder bound"},
                        remainder, e.dv);
                  check(DW'(quotient) * DW'(e.dv) + DW'(remainder) == e.dd,
                        "R3", {e.tag, " identity"},
                        DW'(quotient) * DW'(e.dv) + DW'(remainder), e.dd);
               end
            end
            hold_pending = 1;
            hq = quotient; hr = remainder;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(quotient == 0 && remainder == 0, "R1", "results in reset",
            {quotient, remainder}, 0);
      check(done == 0 && div_ovf == 0, "R1", "flags in reset", {done, div_ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(quotient == 0 && remainder == 0 && done == 0 && div_ovf == 0,
            "R1", "after release", {quotient, remainder, done, div_ovf}, 0);

      // R2: overflow boundary, above it and zero divisor
      issue({6'd9, 6'd5}, 6'd9, 0, "R2 equal");
      issue({6'd40, 6'd1}, 6'd7, 0, "R2 above");
      issue({6'd0, 6'd33}, 6'd0, 0, "R2 zero divisor");
      // R9: flag clears on next start
      issue({6'd0, 6'd20}, 6'd3, 0, "R9 after ovf");
      @(negedge clk);
      check(div_ovf == 0, "R9", "flag after good op", div_ovf, 0);

      // R3 corners
      issue({6'd0, 6'd2}, 6'd5, 0, "R3 zero quotient");
      issue({6'd62, 6'd63}, 6'd63, 0, "R3 max operands");
      issue(12'd4095 >> 6, 6'd1, 0, "R3 unit divisor");
      issue({6'd0, 6'd63}, 6'd1, 0, "R3 all ones quotient");

      // R7: start while busy
      issue({6'd3, 6'd17}, 6'd11, 1, "R7 busy start");
      issue({6'd20, 6'd45}, 6'd33, 1, "R7 busy start big");

      // R8: divisors with the top bit set
      for (int d = 32; d < 64; d++) begin
         logic [W-1:0] hi;
         hi = W'($urandom % d);
         issue({hi, W'($urandom)}, W'(d), 0, "R8 top bit divisor");
      end

      // R3/R4/R5: random operands
      for (int i = 0; i < 200; i++) begin
         logic [W-1:0] dv, hi;
         dv = W'($urandom_range(1, 63));
         hi = W'($urandom % dv);
         issue({hi, W'($urandom)}, dv, (i % 16) == 0, "R3 random");
      end

      repeat (5) @(negedge clk);
      check(sbq.size() == 0, "R6", "scoreboard drained", sbq.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule